// File: doc/BRIEF.md
# Phase-Difference Lock Monitor

This block decides whether a phase-locked loop has settled, working entirely in a fast sampling clock domain. It takes two slow divided clocks, one derived from the reference and one from the loop's feedback path, brings each into the sampling domain through a short synchronizer chain, and XORs them. The XOR duty cycle rises with the phase difference between the two clocks: 0 % when they are aligned and 100 % when they are in antiphase.

A first-order leaky integrator averages the XOR stream. Its time constant is set by a programmable right-shift. The rounded average sits on a 0..256 scale, where 256 means 100 % duty, or 180 degrees. It is compared against an 8-bit phase threshold, where 0 is 0 degrees and 255 is close to 180 degrees. A hysteresis band keeps the flag from chattering. The flag is held low for a blanking window after reset, so the integrator can settle first.

The output is active-low for loss of lock: `lock_ok_o` is high only while the loop is judged locked.

Top module: `phase_lock_monitor`

## Requirements
- R1: Each divided clock passes through a two-flop synchronizer before the XOR. Two divided clocks with the same frequency and zero phase offset produce a filtered value of 0, and after blanking the flag goes high.
- R2: The filtered value is the integrator state rounded to an integer on a 0..256 scale, where 256 means the XOR was high on every sample. A constant-high XOR settles at 256, which is above even the largest threshold code, 255.
- R3: While the flag is high, a filtered value strictly greater than the threshold code drives `lock_ok_o` low on the next decision.
- R4: While the flag is low after blanking, it rises only when filtered value + 4 <= threshold. For values between that bound and the threshold, the flag keeps its current state.
- R5: Each sample moves the integrator by (target - state) arithmetically shifted right by the shift amount. The target is full scale when the XOR is 1 and zero when it is 0. The filtered value therefore never falls while the XOR is 1 and never rises while it is 0.
- R6: The shift amount is taken from `shift_i` and clamped to the range 4..16. Codes below 4 act as 4 and codes above 16 act as 16.
- R7: After reset, `lock_ok_o` stays low for at least 2^shift sampling cycles, and it can rise no more than three cycles after that window ends.
- R8: During reset and in the first cycle after it, `lock_ok_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ref_div_i | input | 1 | Divided reference clock, asynchronous to clk_i |
| fb_div_i | input | 1 | Divided feedback clock, asynchronous to clk_i |
| thr_i | input | 8 | Phase threshold code, 0 = 0 deg, 255 = about 180 deg |
| shift_i | input | 5 | Integrator shift amount, clamped to 4..16 |
| lock_ok_o | output | 1 | High when locked, low on loss of lock or during blanking |

## Verification
The checker watches four things on every cycle:
- the integrator moves in the direction of the current XOR bit;
- the filtered value stays within full scale;
- the effective shift stays inside its clamp;
- every rise or fall of the flag is justified by the filtered value and threshold seen at the decision, with the rise needing the four-code margin.

It also checks that the flag stays low through the shortest possible blanking window.

Some behaviour only the bench scenarios can show:
- that a given phase offset settles to the expected side of a threshold;
- that the hysteresis band really holds the flag in the unlocked state;
- the exact length of the blanking window at the default, minimum-clamped and maximum-clamped shift settings.

// File: rtl/plm_pkg.sv
// Package: shared constants and types for the phase lock monitor.
// Assumes the filtered scale is 0..256 and the threshold is 8 bits wide.
package plm_pkg;
    localparam int THR_W      = 8;
    localparam int SHIFT_W    = 5;
    localparam int MIN_SHIFT  = 4;
    localparam int MAX_SHIFT  = 16;
    localparam int FILT_W     = THR_W + 1;          // holds 0..256
    localparam int FRAC_W     = MAX_SHIFT + 1;      // keeps stall gap below half an LSB
    localparam int ACC_W      = FILT_W + FRAC_W;
    localparam int BLANK_W    = MAX_SHIFT + 2;
    localparam int HYST       = 4;
    localparam int DEF_THR    = 64;
    localparam int DEF_SHIFT  = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_UNLOCK = 2'd1,
        ST_LOCK   = 2'd2
    } lock_state_t;
endpackage

// File: rtl/plm_sync.sv
// Module: multi-flop synchronizer for one asynchronous single-bit input.
// Assumes STAGES >= 2; the input is a slow clock-like signal.
module plm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage captures the asynchronous input.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) chain_q[0] <= 1'b0;
                    else         chain_q[0] <= d_i;
                end
            end else begin : g_next
                // Later stages let metastability resolve.
                always_ff @(posedge clk_i) begin
                    if (!rst_ni) chain_q[i] <= 1'b0;
                    else         chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/plm_cfg.sv
// Module: registers the threshold and the shift amount, clamping the shift.
// Assumes the configuration inputs are quasi-static.
module plm_cfg
    import plm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [THR_W-1:0]   thr_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic [THR_W-1:0]   thr_o,
    output logic [SHIFT_W-1:0] shift_o
);
    logic [SHIFT_W-1:0] shift_clamped;

    // Limit the shift amount to the supported range.
    always_comb begin
        if (shift_i < SHIFT_W'(MIN_SHIFT))      shift_clamped = SHIFT_W'(MIN_SHIFT);
        else if (shift_i > SHIFT_W'(MAX_SHIFT)) shift_clamped = SHIFT_W'(MAX_SHIFT);
        else                                    shift_clamped = shift_i;
    end

    // Capture the configuration, with defaults while in reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            thr_o   <= THR_W'(DEF_THR);
            shift_o <= SHIFT_W'(DEF_SHIFT);
        end else begin
            thr_o   <= thr_i;
            shift_o <= shift_clamped;
        end
    end
endmodule

// File: rtl/plm_filter.sv
// Module: first-order leaky integrator of the phase-error bit.
// Assumes shift_i lies within MIN_SHIFT..MAX_SHIFT.
// The state carries FRAC_W fractional bits. The output is rounded to 0..256.
module plm_filter
    import plm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               err_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic [FILT_W-1:0]  filt_o
);
    localparam logic signed [ACC_W:0] FULL  = (ACC_W+1)'(1) <<< (THR_W + FRAC_W);
    localparam logic        [ACC_W:0] ROUND = (ACC_W+1)'(1) << (FRAC_W - 1);

    logic        [ACC_W-1:0] acc_q;
    logic signed [ACC_W:0]   target;
    logic signed [ACC_W:0]   diff;
    logic signed [ACC_W:0]   step;
    logic        [ACC_W:0]   rounded;

    // Form the step toward the target selected by the error bit.
    always_comb begin
        target = err_i ? FULL : '0;
        diff   = target - $signed({1'b0, acc_q});
        step   = diff >>> shift_i;
    end

    // Advance the integrator state once per sample.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_q + step[ACC_W-1:0];
    end

    // Round the state to the integer output scale.
    always_comb begin
        rounded = {1'b0, acc_q} + ROUND;
        filt_o  = rounded[FRAC_W +: FILT_W];
    end
endmodule

// File: rtl/plm_decide.sv
// Module: blanking counter and hysteretic lock decision.
// Assumes filt_i is already registered upstream and shift_i lies within its clamp.
module plm_decide
    import plm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [FILT_W-1:0]  filt_i,
    input  logic [THR_W-1:0]   thr_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               lock_o
);
    logic [BLANK_W-1:0] blank_q;
    logic [BLANK_W-1:0] blank_limit;
    logic               blank_done;
    logic [FILT_W:0]    filt_margin;
    logic               over_thr;
    logic               under_band;
    lock_state_t        state_q, state_d;

    // Count sampling cycles since reset, saturating at all ones.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)           blank_q <= '0;
        else if (!(&blank_q))  blank_q <= blank_q + 1'b1;
    end

    // Derive the blanking length and the two threshold comparisons.
    always_comb begin
        blank_limit = BLANK_W'(1) << shift_i;
        blank_done  = (blank_q >= blank_limit);
        filt_margin = {1'b0, filt_i} + (FILT_W+1)'(HYST);
        over_thr    = ({1'b0, filt_i} > {2'b00, thr_i});
        under_band  = (filt_margin <= {3'b000, thr_i});
    end

    // Choose the next lock state, applying hysteresis.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_BLANK:  if (blank_done) state_d = ST_UNLOCK;
            ST_UNLOCK: if (under_band) state_d = ST_LOCK;
            ST_LOCK:   if (over_thr)   state_d = ST_UNLOCK;
            default:   state_d = ST_BLANK;
        endcase
    end

    // Hold the lock state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_BLANK;
        else         state_q <= state_d;
    end

    assign lock_o = (state_q == ST_LOCK);
endmodule

// File: rtl/phase_lock_monitor.sv
// Module: top level of the phase lock monitor.
// Synchronizes both divided clocks, XORs them, filters the result and decides on lock.
// Assumes both divided clocks are much slower than clk_i.
module phase_lock_monitor
    import plm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ref_div_i,
    input  logic               fb_div_i,
    input  logic [THR_W-1:0]   thr_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               lock_ok_o
);
    logic [1:0]         raw_w;
    logic [1:0]         syn_w;
    logic               err_w;
    logic [THR_W-1:0]   thr_w;
    logic [SHIFT_W-1:0] shift_w;
    logic [FILT_W-1:0]  filt_w;

    assign raw_w = {fb_div_i, ref_div_i};

    generate
        for (genvar c = 0; c < 2; c++) begin : g_chan
            plm_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .d_i    (raw_w[c]),
                .q_o    (syn_w[c])
            );
        end
    endgenerate

    // Phase error bit: the two synchronized clocks differ.
    assign err_w = syn_w[0] ^ syn_w[1];

    plm_cfg u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .thr_i   (thr_i),
        .shift_i (shift_i),
        .thr_o   (thr_w),
        .shift_o (shift_w)
    );

    plm_filter u_filt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .err_i   (err_w),
        .shift_i (shift_w),
        .filt_o  (filt_w)
    );

    plm_decide u_dec (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .filt_i  (filt_w),
        .thr_i   (thr_w),
        .shift_i (shift_w),
        .lock_o  (lock_ok_o)
    );
endmodule

// File: rtl/plm_checker.sv
// Module: property checker for phase_lock_monitor, attached with a bind statement.
// Assumes the top-level nets filt_w, thr_w, shift_w and err_w exist.
module plm_checker
    import plm_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               lock_ok_o,
    input logic               err,
    input logic [FILT_W-1:0]  filt,
    input logic [THR_W-1:0]   thr,
    input logic [SHIFT_W-1:0] shift
);
    logic [4:0] cyc_q;

    // Count early cycles after reset, up to the shortest blanking window.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        cyc_q <= '0;
        else if (cyc_q < 5'(1 << MIN_SHIFT)) cyc_q <= cyc_q + 1'b1;
    end

    p_blank_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_q < 5'(1 << MIN_SHIFT)) |-> !lock_ok_o);

    p_rise_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_ok_o) |-> ({1'b0, $past(filt)} + 10'(HYST) <= {2'b00, $past(thr)}));

    p_fall_over_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(lock_ok_o) |-> ($past(filt) > {1'b0, $past(thr)}));

    p_rise_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err |=> (filt >= $past(filt)));

    p_fall_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err |=> (filt <= $past(filt)));

    p_filt_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        filt <= FILT_W'(1 << THR_W));

    p_shift_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift >= SHIFT_W'(MIN_SHIFT)) && (shift <= SHIFT_W'(MAX_SHIFT)));
endmodule

bind phase_lock_monitor plm_checker u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_ok_o (lock_ok_o),
    .err       (err_w),
    .filt      (filt_w),
    .thr       (thr_w),
    .shift     (shift_w)
);

// File: tb/tb_phase_lock_monitor.sv
// Bench: drives two divided clocks with a chosen phase offset and checks the lock flag.
module tb_phase_lock_monitor;
    localparam int PERIOD = 32;   // divided clock period in sampling cycles

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ref_div_i = 1'b0;
    logic       fb_div_i = 1'b0;
    logic [7:0] thr_i = 8'd64;
    logic [4:0] shift_i = 5'd8;
    logic       lock_ok_o;

    int checks = 0;
    int errors = 0;
    int offs = 0;
    int ph = 0;

    // Vector fields: {offset, shift, threshold, expected flag}.
    localparam logic [31:0] VECS [7] = '{
        {8'd0,  8'd6, 8'd64,  8'd1},   // R1 aligned clocks lock
        {8'd8,  8'd8, 8'd64,  8'd0},   // R3 90 deg against 45 deg
        {8'd2,  8'd8, 8'd64,  8'd1},   // R4 small offset relocks
        {8'd16, 8'd6, 8'd255, 8'd0},   // R2 antiphase beats max code
        {8'd12, 8'd8, 8'd255, 8'd1},   // R5 three-quarter duty
        {8'd6,  8'd8, 8'd40,  8'd0},   // R3 96 over 40
        {8'd4,  8'd8, 8'd100, 8'd1}    // R4 64 well under 100
    };

    phase_lock_monitor dut (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ref_div_i (ref_div_i),
        .fb_div_i  (fb_div_i),
        .thr_i     (thr_i),
        .shift_i   (shift_i),
        .lock_ok_o (lock_ok_o)
    );

    always #2.5 clk_i = ~clk_i;

    // Generate the divided clocks away from the sampling edge.
    always @(negedge clk_i) begin
        ph = (ph + 1) % PERIOD;
        ref_div_i = (ph < PERIOD/2);
        fb_div_i  = (((ph + PERIOD - offs) % PERIOD) < PERIOD/2);
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic check(input logic exp, input string req);
        checks++;
        if (lock_ok_o !== exp) begin
            errors++;
            $display("FAIL %s: lock_ok_o=%b expected %b at %0t", req, lock_ok_o, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        wait_cyc(4);
        rst_ni = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk_i);
        rst_ni = 1'b0;
        wait_cyc(2);
        check(1'b0, "R8 in reset");
        do_reset();
        wait_cyc(1);
        check(1'b0, "R8 after reset");
        wait_cyc(239);
        check(1'b0, "R7 blank default shift");
        wait_cyc(40);
        check(1'b1, "R7 blank ended");

        for (int v = 0; v < 7; v++) begin
            offs    = int'(VECS[v][31:24]);
            shift_i = VECS[v][20:16];
            thr_i   = VECS[v][15:8];
            wait_cyc(4000);
            check(VECS[v][0], $sformatf("vector %0d (R1 R2 R3 R4 R5)", v));
        end

        // R4 hysteresis: filtered value near 128 with light ripple.
        offs = 8; shift_i = 5'd10; thr_i = 8'd140;
        wait_cyc(12000);
        check(1'b1, "R4 below band locks");
        thr_i = 8'd124;
        wait_cyc(3000);
        check(1'b0, "R3 over threshold drops");
        thr_i = 8'd129;
        wait_cyc(3000);
        check(1'b0, "R4 inside band holds low");
        thr_i = 8'd135;
        wait_cyc(3000);
        check(1'b1, "R4 below band relocks");

        // R6 low clamp: code 2 acts as 4, so blanking is 16 cycles.
        offs = 0; thr_i = 8'd64; shift_i = 5'd2;
        do_reset();
        wait_cyc(10);
        check(1'b0, "R6 low clamp blank");
        wait_cyc(30);
        check(1'b1, "R6 low clamp lock");

        // R6 high clamp: code 31 acts as 16, so blanking is 65536 cycles.
        shift_i = 5'd31;
        do_reset();
        wait_cyc(60000);
        check(1'b0, "R6 high clamp blank");
        wait_cyc(6000);
        check(1'b1, "R6 high clamp lock");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule